// File: doc/BRIEF.md
# Framed Serial Codec Shifter with FIFO Alarms

This block moves audio-style data words between a host and a full-duplex serial codec link. The host writes bytes into a 64-byte transmit FIFO and reads bytes from a 64-byte receive FIFO. On the serial side, a separate clock generator supplies single-cycle strobes marking the rising and falling edges of the bit clock, together with a frame-sync level. Each rising edge of frame sync starts one word in each direction. The word length is selectable as 8, 16, 24 or 32 bits, and every word is stored in the FIFOs as whole bytes, most significant byte first.

Two fill-level comparators produce alarms. The transmit alarm counts the bytes still queued for sending. The receive alarm counts the space still free. The transmit alarm, gated by an enable, also drives a transmit-ready interrupt. Sticky flags record a transmit word that could not be supplied (underrun) and a received word that could not be stored (overrun). Each FIFO has its own flush input, which empties that FIFO and clears its flag.

Top module: `fsc_codec_shifter`

## Requirements
- R1: `cfg_wlen` selects the word length: 0 = 8 bits, 1 = 16, 2 = 24, 3 = 32. A word occupies 1 to 4 FIFO bytes, and the earliest byte in the FIFO is the word's most significant byte.
- R2: `sdout` changes only on cycles where `bit_rise` is high. It carries the word most significant bit first, and the first bit appears at the frame-start rising strobe. After the last bit of the word, `sdout` is 0.
- R3: A frame starts only on a `bit_rise` strobe where `fsync` is 1 and `fsync` was 0 at the previous `bit_rise` strobe. Holding `fsync` high starts exactly one word.
- R4: After a frame start, `sdin` is sampled on each of the next word-length `bit_fall` strobes, most significant bit first. The word is then pushed into the receive FIFO as bytes, most significant byte first.
- R5: `tx_alarm` is 1 exactly when the number of bytes in the transmit FIFO is less than or equal to `tx_lvl` (for example, 16 = 0x010).
- R6: `rx_alarm` is 1 exactly when the free space in the receive FIFO (64 minus the bytes held) is less than or equal to `rx_lvl` (for example, 12 = 0x00C).
- R7: `txrdy_irq` equals `tx_alarm` when `txrdy_en` is 1, and is 0 otherwise.
- R8: If the transmit FIFO holds fewer bytes than one word at frame start, the block pops nothing, sends an all-zero word and sets `tx_underrun`. The flag stays set until `tx_flush`.
- R9: If the receive FIFO lacks room for a whole completed word, the word is dropped and `rx_overrun` is set. The flag stays set until `rx_flush`.
- R10: A `tx_push` while `tx_full` is 1 is ignored. A `rx_pop` while `rx_empty` is 1 is ignored.
- R11: `tx_flush` empties the transmit FIFO and `rx_flush` empties the receive FIFO, in one cycle each.
- R12: After reset both FIFOs are empty, both sticky flags are 0 and `sdout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_rise | input | 1 | One-cycle strobe at each bit-clock rising edge |
| bit_fall | input | 1 | One-cycle strobe at each bit-clock falling edge |
| fsync | input | 1 | Frame sync level, sampled at rising strobes |
| sdin | input | 1 | Serial receive data |
| sdout | output | 1 | Serial transmit data |
| tx_push | input | 1 | Write one byte into the transmit FIFO |
| tx_byte | input | 8 | Byte to write |
| tx_full | output | 1 | Transmit FIFO holds 64 bytes |
| rx_pop | input | 1 | Remove the head byte of the receive FIFO |
| rx_byte | output | 8 | Head byte of the receive FIFO |
| rx_empty | output | 1 | Receive FIFO is empty |
| tx_flush | input | 1 | Empty the transmit FIFO and clear the underrun flag |
| rx_flush | input | 1 | Empty the receive FIFO and clear the overrun flag |
| cfg_wlen | input | 2 | Word length select |
| tx_lvl | input | 7 | Transmit alarm threshold, in bytes stored |
| rx_lvl | input | 7 | Receive alarm threshold, in bytes free |
| txrdy_en | input | 1 | Transmit-ready interrupt enable |
| tx_alarm | output | 1 | Transmit fill at or below threshold |
| rx_alarm | output | 1 | Receive free space at or below threshold |
| txrdy_irq | output | 1 | Transmit-ready interrupt |
| tx_underrun | output | 1 | Sticky transmit underrun flag |
| rx_overrun | output | 1 | Sticky receive overrun flag |

## Verification
The hardest state to reach is a receive overrun. It needs a receive FIFO with fewer free bytes than one word, and a host that is not reading. The bench stops its reader and, with the transmit side deliberately empty, runs zero-filled 24-bit frames in a loopback. This fills the receive FIFO three bytes at a time. It passes the receive-alarm threshold at 54 bytes and ends at 63, so the next word must be dropped; the reader then confirms that exactly 63 bytes were kept. A long `fsync` pulse covering several word times checks that only its leading edge starts a transfer.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
    localparam int BYTE_W    = 8;
    localparam int MAX_BYTES = 4;
    localparam int WORD_W    = BYTE_W * MAX_BYTES;

    typedef enum logic [1:0] {
        WL_8  = 2'd0,
        WL_16 = 2'd1,
        WL_24 = 2'd2,
        WL_32 = 2'd3
    } wlen_e;

    typedef logic [2:0] nbytes_t;
    typedef logic [5:0] nbits_t;

    // Strobes that drive the two shifters in one cycle.
    typedef struct packed {
        logic start;
        logic rise;
        logic fall;
    } strobe_t;

    function automatic nbytes_t wlen_bytes(input wlen_e wl);
        return nbytes_t'({1'b0, wl}) + 3'd1;
    endfunction

    function automatic nbits_t wlen_bits(input wlen_e wl);
        return {wlen_bytes(wl), 3'b000};
    endfunction
endpackage

// File: rtl/fsc_fifo.sv
// Byte FIFO with multi-byte write and read ports. DEPTH must be a power of two.
module fsc_fifo #(
    parameter int DEPTH = 64,
    parameter int WR_B  = 1,
    parameter int RD_B  = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int WNW  = $clog2(WR_B + 1),
    localparam int RNW  = $clog2(RD_B + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [WNW-1:0]    wr_n,
    input  logic [WR_B*8-1:0] wr_data,
    input  logic [RNW-1:0]    rd_n,
    output logic [RD_B*8-1:0] rd_data,
    output logic [CW-1:0]     count
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        if (!rst && !flush) begin
            for (int k = 0; k < WR_B; k++) begin
                if (k < int'(wr_n)) mem[wr_ptr + AW'(k)] <= wr_data[k*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(wr_n);
            rd_ptr <= rd_ptr + AW'(rd_n);
            count  <= count + CW'(wr_n) - CW'(rd_n);
        end
    end

    for (genvar g = 0; g < RD_B; g++) begin : g_rd
        assign rd_data[g*8 +: 8] = mem[rd_ptr + AW'(g)];
    end

    // Callers guarantee these; a violation would corrupt the byte order.
    p_no_overfill_r10: assert property (@(posedge clk) disable iff (rst)
        !flush |-> (int'(count) + int'(wr_n) - int'(rd_n) <= DEPTH));
    p_no_underread_r8: assert property (@(posedge clk) disable iff (rst)
        !flush |-> (CW'(rd_n) <= count));
endmodule

// File: rtl/fsc_tx_shift.sv
module fsc_tx_shift
    import fsc_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_flag,
    input  strobe_t           stb,
    input  nbytes_t           nb,
    input  logic [CW-1:0]     avail,
    input  logic [WORD_W-1:0] head,
    output nbytes_t           pop_n,
    output logic              sdout,
    output logic              underrun
);
    logic [WORD_W-1:0] sh, load_word;
    logic              enough;

    assign enough = avail >= CW'(nb);

    // Earliest FIFO byte lands in the top byte of the shifter.
    always_comb begin
        load_word = '0;
        for (int k = 0; k < MAX_BYTES; k++) begin
            if (k < int'(nb)) load_word[WORD_W-1-8*k -: 8] = head[8*k +: 8];
        end
    end

    assign pop_n = (stb.start && enough) ? nb : '0;
    assign sdout = sh[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            underrun <= 1'b0;
        end else begin
            if (stb.start)     sh <= enough ? load_word : '0;
            else if (stb.rise) sh <= {sh[WORD_W-2:0], 1'b0};
            if (clr_flag)                  underrun <= 1'b0;
            else if (stb.start && !enough) underrun <= 1'b1;
        end
    end

    p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        underrun && !clr_flag |=> underrun);
    p_short_sends_zero_r8: assert property (@(posedge clk) disable iff (rst)
        stb.start && !enough |=> !sdout);
    p_msb_first_r2: assert property (@(posedge clk) disable iff (rst)
        stb.start && enough |=> sdout == $past(head[7]));
    p_change_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
        !stb.rise && !stb.start |=> $stable(sdout));
endmodule

// File: rtl/fsc_rx_shift.sv
module fsc_rx_shift
    import fsc_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW    = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_flag,
    input  strobe_t           stb,
    input  logic              sdin,
    input  nbytes_t           nb,
    input  logic [CW-1:0]     used,
    output nbytes_t           push_n,
    output logic [WORD_W-1:0] push_data,
    output logic              overrun
);
    logic [WORD_W-2:0] sh;
    logic [WORD_W-1:0] word;
    nbits_t            cnt, nbits;
    logic              active, last, room;
    logic [CW:0]       need;

    assign nbits = {nb, 3'b000};
    assign word  = {sh, sdin};
    assign last  = active && stb.fall && (cnt == nbits - 6'd1);
    assign need  = {1'b0, used} + {{(CW-2){1'b0}}, nb};
    assign room  = need <= (CW+1)'(DEPTH);
    assign push_n = (last && room) ? nb : '0;

    // Most significant byte of the finished word goes into the FIFO first.
    always_comb begin
        push_data = '0;
        for (int k = 0; k < MAX_BYTES; k++) begin
            if (k < int'(nb)) push_data[8*k +: 8] = 8'(word >> (8 * (int'(nb) - 1 - k)));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            cnt     <= '0;
            active  <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (stb.start) begin
                active <= 1'b1;
                cnt    <= '0;
            end else if (stb.fall && active) begin
                sh  <= word[WORD_W-2:0];
                cnt <= cnt + 6'd1;
                if (last) active <= 1'b0;
            end
            if (clr_flag)          overrun <= 1'b0;
            else if (last && !room) overrun <= 1'b1;
        end
    end

    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        overrun && !clr_flag |=> overrun);
    p_drop_flags_r9: assert property (@(posedge clk) disable iff (rst)
        last && !room && !clr_flag |=> overrun);
    p_push_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
        push_n != '0 |-> stb.fall);
endmodule

// File: rtl/fsc_codec_shifter.sv
module fsc_codec_shifter
    import fsc_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_rise,
    input  logic          bit_fall,
    input  logic          fsync,
    input  logic          sdin,
    output logic          sdout,
    input  logic          tx_push,
    input  logic [7:0]    tx_byte,
    output logic          tx_full,
    input  logic          rx_pop,
    output logic [7:0]    rx_byte,
    output logic          rx_empty,
    input  logic          tx_flush,
    input  logic          rx_flush,
    input  logic [1:0]    cfg_wlen,
    input  logic [CW-1:0] tx_lvl,
    input  logic [CW-1:0] rx_lvl,
    input  logic          txrdy_en,
    output logic          tx_alarm,
    output logic          rx_alarm,
    output logic          txrdy_irq,
    output logic          tx_underrun,
    output logic          rx_overrun
);
    wlen_e             wl;
    nbytes_t           nb, tx_pop_n, rx_push_n;
    strobe_t           stb;
    logic              fs_prev;
    logic [CW-1:0]     tx_cnt, rx_cnt, rx_free;
    logic [WORD_W-1:0] tx_head, rx_word;

    assign wl = wlen_e'(cfg_wlen);
    assign nb = wlen_bytes(wl);

    // Frame start: fsync seen high at a rising strobe after being low at the last one.
    always_ff @(posedge clk) begin
        if (rst)           fs_prev <= 1'b0;
        else if (bit_rise) fs_prev <= fsync;
    end

    assign stb.start = bit_rise && fsync && !fs_prev;
    assign stb.rise  = bit_rise;
    assign stb.fall  = bit_fall;

    fsc_fifo #(.DEPTH(DEPTH), .WR_B(1), .RD_B(MAX_BYTES)) u_tx_fifo (
        .clk     (clk),
        .rst     (rst),
        .flush   (tx_flush),
        .wr_n    (tx_push && !tx_full),
        .wr_data (tx_byte),
        .rd_n    (tx_pop_n),
        .rd_data (tx_head),
        .count   (tx_cnt)
    );

    fsc_fifo #(.DEPTH(DEPTH), .WR_B(MAX_BYTES), .RD_B(1)) u_rx_fifo (
        .clk     (clk),
        .rst     (rst),
        .flush   (rx_flush),
        .wr_n    (rx_push_n),
        .wr_data (rx_word),
        .rd_n    (rx_pop && !rx_empty),
        .rd_data (rx_byte),
        .count   (rx_cnt)
    );

    fsc_tx_shift #(.CW(CW)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .clr_flag (tx_flush),
        .stb      (stb),
        .nb       (nb),
        .avail    (tx_cnt),
        .head     (tx_head),
        .pop_n    (tx_pop_n),
        .sdout    (sdout),
        .underrun (tx_underrun)
    );

    fsc_rx_shift #(.DEPTH(DEPTH), .CW(CW)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .clr_flag  (rx_flush),
        .stb       (stb),
        .sdin      (sdin),
        .nb        (nb),
        .used      (rx_cnt),
        .push_n    (rx_push_n),
        .push_data (rx_word),
        .overrun   (rx_overrun)
    );

    assign tx_full   = tx_cnt == CW'(DEPTH);
    assign rx_empty  = rx_cnt == '0;
    assign rx_free   = CW'(DEPTH) - rx_cnt;
    assign tx_alarm  = tx_cnt <= tx_lvl;
    assign rx_alarm  = rx_free <= rx_lvl;
    assign txrdy_irq = txrdy_en && tx_alarm;

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (rst)
        !txrdy_en |-> !txrdy_irq);
    p_start_needs_edge_r3: assert property (@(posedge clk) disable iff (rst)
        bit_rise && fs_prev |-> !stb.start);
    p_full_rejects_r10: assert property (@(posedge clk) disable iff (rst)
        tx_full && !tx_flush && tx_pop_n == '0 |=> tx_full);
endmodule

// File: tb/fsc_codec_shifter_tb.sv
module fsc_codec_shifter_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_rise = 0, bit_fall = 0, fsync = 0, sdin;
    logic       sdout, tx_push = 0, tx_full, rx_pop = 0, rx_empty;
    logic [7:0] tx_byte = '0, rx_byte;
    logic       tx_flush = 0, rx_flush = 0, txrdy_en = 1;
    logic [1:0] cfg_wlen = 2'd2;
    logic [6:0] tx_lvl = 7'd16, rx_lvl = 7'd12;
    logic       tx_alarm, rx_alarm, txrdy_irq, tx_underrun, rx_overrun;

    always #2.5 clk = ~clk;
    assign sdin = sdout; // loopback

    fsc_codec_shifter dut_i (
        .clk(clk), .rst(rst), .bit_rise(bit_rise), .bit_fall(bit_fall), .fsync(fsync),
        .sdin(sdin), .sdout(sdout), .tx_push(tx_push), .tx_byte(tx_byte), .tx_full(tx_full),
        .rx_pop(rx_pop), .rx_byte(rx_byte), .rx_empty(rx_empty), .tx_flush(tx_flush),
        .rx_flush(rx_flush), .cfg_wlen(cfg_wlen), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
        .txrdy_en(txrdy_en), .tx_alarm(tx_alarm), .rx_alarm(rx_alarm), .txrdy_irq(txrdy_irq),
        .tx_underrun(tx_underrun), .rx_overrun(rx_overrun)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [7:0] tm_q[$];   // transmit FIFO model
    logic [7:0] exp_q[$];  // scoreboard of expected receive bytes
    bit mon_on = 0, gen_on = 0, hold_hi = 0;
    int ph = 0, bitidx = 0, flen = 26, wbits = 24, nbytes = 3, frames_left = 0, cap_n = 0;
    logic [31:0] cap = '0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 37 + 5);
    endfunction

    // Bit-clock strobes: 8 system clocks per bit, rise at phase 0, fall at phase 4.
    always @(negedge clk) begin
        bit_rise = 0;
        bit_fall = 0;
        if (gen_on) begin
            ph = (ph + 1) % 8;
            if (ph == 0) begin
                bit_rise = 1;
                if (hold_hi) fsync = 1;
                else if (bitidx == 0 && frames_left > 0) begin
                    fsync = 1;
                    frames_left--;
                    cap = '0;
                    cap_n = 0;
                end else fsync = 0;
                bitidx = (bitidx + 1) % flen;
            end else if (ph == 4) begin
                bit_fall = 1;
                if (cap_n < wbits) begin
                    cap = {cap[30:0], sdout};
                    cap_n++;
                end
            end
        end
    end

    // Scoreboard monitor: pops the receive FIFO and compares against the queue.
    always @(negedge clk) begin
        rx_pop = 0;
        if (mon_on && !rst && !rx_empty) begin
            if (exp_q.size() == 0) check(0, "R4 unexpected rx byte", {24'h0, rx_byte}, 32'h0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(rx_byte == e, "R4 rx byte", {24'h0, rx_byte}, {24'h0, e});
            end
            rx_pop = 1;
        end
    end

    task automatic push_tx(input logic [7:0] b);
        @(negedge clk);
        tx_push = 1;
        tx_byte = b;
        if (tm_q.size() < 64) tm_q.push_back(b);
        @(negedge clk);
        tx_push = 0;
    endtask

    task automatic model_frame();
        logic [7:0] w[$];
        if (tm_q.size() >= nbytes) begin
            for (int i = 0; i < nbytes; i++) w.push_back(tm_q.pop_front());
        end else begin
            for (int i = 0; i < nbytes; i++) w.push_back(8'h00);
        end
        if (mon_on || exp_q.size() + nbytes <= 64) begin
            foreach (w[i]) exp_q.push_back(w[i]);
        end
    endtask

    task automatic run_frames(input int n);
        for (int i = 0; i < n; i++) model_frame();
        frames_left = n;
        while (frames_left != 0) @(posedge clk);
        repeat (flen * 8 + 40) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_wlen(input int code);
        @(negedge clk);
        cfg_wlen = 2'(code);
        nbytes = code + 1;
        wbits = nbytes * 8;
        flen = wbits + 2;
        bitidx = 0;
    endtask

    task automatic pulse_tx_flush();
        @(negedge clk); tx_flush = 1;
        @(negedge clk); tx_flush = 0;
        tm_q.delete();
    endtask

    task automatic pulse_rx_flush();
        @(negedge clk); rx_flush = 1;
        @(negedge clk); rx_flush = 0;
        exp_q.delete();
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog expired", 32'h0, 32'h1);
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R12 reset state
        check(sdout == 0, "R12 sdout", {31'h0, sdout}, 32'h0);
        check(rx_empty == 1, "R12 rx_empty", {31'h0, rx_empty}, 32'h1);
        check(tx_underrun == 0 && rx_overrun == 0, "R12 flags", {30'h0, tx_underrun, rx_overrun}, 32'h0);
        check(tx_alarm == 1 && rx_alarm == 0, "R5 R6 alarms after reset", {30'h0, tx_alarm, rx_alarm}, 32'h2);
        check(txrdy_irq == 1, "R7 irq after reset", {31'h0, txrdy_irq}, 32'h1);

        gen_on = 1;
        set_wlen(2);
        // R5 threshold 16 bytes
        for (int i = 0; i < 16; i++) push_tx(pat(i));
        check(tx_alarm == 1, "R5 alarm at level", {31'h0, tx_alarm}, 32'h1);
        push_tx(pat(16));
        check(tx_alarm == 0, "R5 alarm above level", {31'h0, tx_alarm}, 32'h0);
        check(txrdy_irq == 0, "R7 irq follows alarm", {31'h0, txrdy_irq}, 32'h0);

        // R1 R2 R4: 24-bit loopback
        mon_on = 1;
        run_frames(5);
        check(cap[23:0] == {pat(12), pat(13), pat(14)}, "R2 24-bit serial word", cap, {8'h0, pat(12), pat(13), pat(14)});
        check(tx_underrun == 0, "R8 no underrun yet", {31'h0, tx_underrun}, 32'h0);
        // R8: two bytes left, less than a word
        run_frames(1);
        check(tx_underrun == 1, "R8 underrun set", {31'h0, tx_underrun}, 32'h1);
        check(cap[23:0] == 24'h0, "R8 zero word", cap, 32'h0);
        pulse_tx_flush();
        check(tx_underrun == 0, "R8 R11 flush clears underrun", {31'h0, tx_underrun}, 32'h0);
        check(tx_alarm == 1, "R11 tx empty after flush", {31'h0, tx_alarm}, 32'h1);

        // R1 other word lengths
        set_wlen(1);
        for (int i = 0; i < 4; i++) push_tx(pat(100 + i));
        run_frames(2);
        check(cap[15:0] == {pat(102), pat(103)}, "R1 16-bit word", cap, {16'h0, pat(102), pat(103)});
        set_wlen(0);
        for (int i = 0; i < 3; i++) push_tx(pat(120 + i));
        run_frames(3);
        check(cap[7:0] == pat(122), "R1 8-bit word", cap, {24'h0, pat(122)});
        set_wlen(3);
        for (int i = 0; i < 8; i++) push_tx(pat(140 + i));
        run_frames(2);
        check(cap == {pat(144), pat(145), pat(146), pat(147)}, "R1 32-bit word", cap, {pat(144), pat(145), pat(146), pat(147)});

        // R7 mask
        txrdy_en = 0;
        @(negedge clk);
        check(txrdy_irq == 0 && tx_alarm == 1, "R7 masked irq", {30'h0, txrdy_irq, tx_alarm}, 32'h1);
        txrdy_en = 1;
        @(negedge clk);
        check(txrdy_irq == 1, "R7 enabled irq", {31'h0, txrdy_irq}, 32'h1);

        // R3: long fsync high starts one word only
        set_wlen(2);
        for (int i = 0; i < 6; i++) push_tx(pat(160 + i));
        model_frame();
        @(negedge clk); hold_hi = 1;
        repeat (flen * 8 * 3) @(negedge clk);
        hold_hi = 0;
        repeat (flen * 8 + 40) @(negedge clk);
        check(exp_q.size() == 0, "R3 one word per leading edge", exp_q.size(), 32'h0);
        run_frames(1);
        check(cap[23:0] == {pat(163), pat(164), pat(165)}, "R3 next word intact", cap, {8'h0, pat(163), pat(164), pat(165)});

        // R10: push into full transmit FIFO ignored
        set_wlen(0);
        for (int i = 0; i < 66; i++) push_tx(pat(200 + i));
        check(tx_full == 1, "R10 tx full", {31'h0, tx_full}, 32'h1);
        run_frames(65);
        check(exp_q.size() == 0, "R10 only 64 bytes kept", exp_q.size(), 32'h0);
        check(tx_underrun == 1, "R8 R10 underrun after 64", {31'h0, tx_underrun}, 32'h1);
        pulse_tx_flush();

        // R6 R9: fill receive FIFO with reader stopped
        mon_on = 0;
        set_wlen(2);
        run_frames(17);
        check(rx_alarm == 0, "R6 free 13 above level", {31'h0, rx_alarm}, 32'h0);
        run_frames(1);
        check(rx_alarm == 1, "R6 free 10 at or below level", {31'h0, rx_alarm}, 32'h1);
        run_frames(4);
        check(rx_overrun == 1, "R9 overrun set", {31'h0, rx_overrun}, 32'h1);
        mon_on = 1;
        repeat (200) @(negedge clk);
        check(exp_q.size() == 0 && rx_empty == 1, "R9 dropped word not stored", exp_q.size(), 32'h0);
        check(rx_overrun == 1, "R9 overrun sticky", {31'h0, rx_overrun}, 32'h1);
        mon_on = 0;
        run_frames(2);
        check(rx_empty == 0, "R11 rx holds data", {31'h0, rx_empty}, 32'h0);
        pulse_rx_flush();
        check(rx_empty == 1 && rx_overrun == 0, "R11 R9 rx flush", {30'h0, rx_empty, rx_overrun}, 32'h2);
        check(rx_alarm == 0, "R6 R11 alarm after flush", {31'h0, rx_alarm}, 32'h0);
        // R10: pop from empty ignored
        @(negedge clk); rx_pop = 1;
        @(negedge clk); rx_pop = 0;
        check(rx_empty == 1 && rx_alarm == 0, "R10 pop on empty ignored", {30'h0, rx_empty, rx_alarm}, 32'h2);
        finish_up();
    end
endmodule